// File: doc/BRIEF.md
# Double-Buffered Time-Slot Route Table

This block holds the per-slot route entries for a serial interface with two time-division ports, each with a receive side and a transmit side. That gives four independent sections. The table has 512 words. Each section owns 128 contiguous words, split into two 64-word halves. One half is the live route. A per-section slot counter walks through it entry by entry as the frame plays out. The other half is a standby copy that the host may rewrite at any time.

To change a route, the host fills the standby half and then pulses that section's change request. The request stays pending until the section's next frame-sync pulse. At that edge the two halves exchange roles, the slot counter restarts at the base of the newly live half, and the request clears by itself. A frame is therefore never split between two routes.

The host can read any word at any time. A write aimed at a section's live half is dropped and flagged. The block reports, per section:
- which half is live;
- whether a request is pending;
- the table address of the entry being executed;
- that entry's contents;
- a strobe bit taken from that entry.

Top module: `rt_route_table`

## Requirements
- R1: After reset, every section has half 0 live (`live_half` = 0), no request pending, `wr_reject` = 0, and each pointer at its section base: 0, 128, 256, 384.
- R2: Table address = section×128 + half×64 + slot index. Section numbers are 0 = receive A, 1 = receive B, 2 = transmit A, 3 = transmit B. Pointer `s` occupies `exec_ptr[9s+8:9s]`.
- R3: A frame sync on a section with a request pending toggles its live half and clears the request. A frame sync with no request pending leaves the live half unchanged.
- R4: A request pulse sets the section's pending bit. The live half does not change until that section's next frame sync.
- R5: In the cycle after a frame sync, the section's pointer is at slot 0 of its (possibly new) live half.
- R6: A slot tick on an entry whose last bit (bit 0) is clear advances the pointer by one. From slot 63 it goes to slot 0 of the same half.
- R7: A slot tick on an entry with the last bit set goes to slot 0 of the live half when its wrap bit (bit 1) is 1, and holds the pointer when bit 1 is 0.
- R8: `slot_strobe[s]` equals bit 2 of the entry at section `s`'s pointer, and `slot_entry` carries that entry.
- R9: A host write to a standby half stores the word. `host_rdata` returns the word at `host_addr` one clock after the address is presented.
- R10: A host write to a live half leaves the table unchanged and raises `wr_reject` for exactly the following cycle.
- R11: A request, sync or tick on one section changes neither the live half, the pending bit nor the pointer of any other section.
- R12: A request arriving on the same edge as a frame sync with nothing pending does not swap. It is left pending for the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host read/write address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| wr_reject | output | 1 | Previous-cycle write hit a live half |
| chg_req | input | 4 | Per-section change request pulse |
| frame_sync | input | 4 | Per-section frame-sync pulse |
| slot_tick | input | 4 | Per-section slot advance |
| live_half | output | 4 | Live half per section |
| chg_pend | output | 4 | Pending request per section |
| exec_ptr | output | 36 | Executing entry address, 9 bits per section |
| slot_entry | output | 64 | Executing entry word, 16 bits per section |
| slot_strobe | output | 4 | Strobe bit of executing entry |

## Verification
The bench first fills every standby half, then requests a swap on all four sections together. It steps one section at a time so that the untouched sections' pointers show that sections do not interfere with each other. Tick patterns are chosen to separate plain advance, natural rollover at slot 63, the last-with-wrap return and the last-with-hold stall. Syncs are applied with and without a pending request, and once on the same edge as a new request, to tell a real swap from a restart alone. A write aimed at a live half is read back afterwards to show that the old word survived.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int NUM_SEC = 4;
  localparam int SEC_W   = 2;
  localparam int F_LAST  = 0;
  localparam int F_WRAP  = 1;
  localparam int F_STB   = 2;
  typedef enum logic [SEC_W-1:0] {
    SEC_RX_A = 2'd0,
    SEC_RX_B = 2'd1,
    SEC_TX_A = 2'd2,
    SEC_TX_B = 2'd3
  } sec_e;
endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sff_q <= 2'b00;
    else        sff_q <= {sff_q[0], 1'b1};
  end

  assign rst_sync_n = sff_q[1];
endmodule

// File: rtl/rt_table_mem.sv
module rt_table_mem #(
  parameter int ENTRY_W = 16,
  parameter int ADDR_W  = 9,
  parameter int NRD     = 4
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [ENTRY_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]     host_raddr,
  output logic [ENTRY_W-1:0]    host_rdata,
  input  logic [NRD*ADDR_W-1:0] rd_addr,
  output logic [NRD*ENTRY_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [ENTRY_W-1:0] hrd_d;

  // write port, clock-enabled
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  // host read: always active, one-cycle latency
  always_comb hrd_d = mem_q[host_raddr];

  always_ff @(posedge clk) begin
    host_rdata <= hrd_d;
  end

  // per-section execution read ports
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g*ENTRY_W +: ENTRY_W] = mem_q[rd_addr[g*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/rt_wr_guard.sv
module rt_wr_guard #(
  parameter int NSEC = 4,
  parameter int SW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [SW-1:0]   host_sec,
  input  logic            host_half,
  input  logic [NSEC-1:0] live_half,
  output logic            wr_ok,
  output logic            wr_reject
);
  logic hit_live;
  logic rej_d;
  logic rej_q;

  always_comb begin
    hit_live = (host_half == live_half[host_sec]);
    wr_ok    = host_we & ~hit_live;
    rej_d    = host_we & hit_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rej_q <= 1'b0;
    else        rej_q <= rej_d;
  end

  assign wr_reject = rej_q;

  // a flagged write was a real write in the prior cycle, and it was not stored
  assert_reject_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(host_we) && !$past(wr_ok));
endmodule

// File: rtl/rt_sect_seq.sv
module rt_sect_seq #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 9,
  parameter int SEC_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_req,
  input  logic              fsync,
  input  logic              tick,
  input  logic              ent_last,
  input  logic              ent_wrap,
  output logic              half_o,
  output logic              pend_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int SEC_W = ADDR_W - IDX_W - 1;
  localparam logic [SEC_W-1:0] SEC_V = SEC_W'(SEC_ID);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             half_q, half_d;
  logic             pend_q, pend_d;
  logic             st_en;

  // next-state
  always_comb begin
    idx_d  = idx_q;
    half_d = half_q;
    pend_d = pend_q | chg_req;
    if (fsync) begin
      half_d = half_q ^ pend_q;
      idx_d  = '0;
      pend_d = chg_req;
    end else if (tick) begin
      if (!ent_last)     idx_d = idx_q + 1'b1;
      else if (ent_wrap) idx_d = '0;
      else               idx_d = idx_q;
    end
    st_en = fsync | tick | chg_req;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      half_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (st_en) begin
      idx_q  <= idx_d;
      half_q <= half_d;
      pend_q <= pend_d;
    end
  end

  assign half_o = half_q;
  assign pend_o = pend_q;
  assign ptr_o  = {SEC_V, half_q, idx_q};

  assert_sync_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (idx_q == '0));
  assert_swap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && pend_q && !chg_req) |=> (!pend_q && half_q != $past(half_q)));
  assert_half_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fsync && pend_q) |=> $stable(half_q));
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fsync && !ent_last) |=> (idx_q == $past(idx_q) + 1'b1));
  assert_last_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fsync && ent_last && !ent_wrap) |=> $stable(idx_q));
endmodule

// File: rtl/rt_route_table.sv
module rt_route_table #(
  parameter int ENTRY_W = 16,
  parameter int SLOT_AW = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_we,
  input  logic [rt_pkg::SEC_W+SLOT_AW:0]    host_addr,
  input  logic [ENTRY_W-1:0]                host_wdata,
  output logic [ENTRY_W-1:0]                host_rdata,
  output logic                              wr_reject,
  input  logic [rt_pkg::NUM_SEC-1:0]        chg_req,
  input  logic [rt_pkg::NUM_SEC-1:0]        frame_sync,
  input  logic [rt_pkg::NUM_SEC-1:0]        slot_tick,
  output logic [rt_pkg::NUM_SEC-1:0]        live_half,
  output logic [rt_pkg::NUM_SEC-1:0]        chg_pend,
  output logic [rt_pkg::NUM_SEC*(rt_pkg::SEC_W+SLOT_AW+1)-1:0] exec_ptr,
  output logic [rt_pkg::NUM_SEC*ENTRY_W-1:0] slot_entry,
  output logic [rt_pkg::NUM_SEC-1:0]        slot_strobe
);
  import rt_pkg::*;

  localparam int ADDR_W = SEC_W + SLOT_AW + 1;

  logic               srst_n;
  logic               mem_we;
  logic [SEC_W-1:0]   host_sec;
  logic               host_half;
  logic [NUM_SEC*ADDR_W-1:0]  ptr_bus;
  logic [NUM_SEC*ENTRY_W-1:0] ent_bus;

  assign host_sec  = host_addr[ADDR_W-1 -: SEC_W];
  assign host_half = host_addr[SLOT_AW];

  rt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  rt_wr_guard #(.NSEC(NUM_SEC), .SW(SEC_W)) u_guard (
    .clk       (clk),
    .rst_n     (srst_n),
    .host_we   (host_we),
    .host_sec  (host_sec),
    .host_half (host_half),
    .live_half (live_half),
    .wr_ok     (mem_we),
    .wr_reject (wr_reject)
  );

  rt_table_mem #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .NRD(NUM_SEC)) u_mem (
    .clk        (clk),
    .wr_en      (mem_we),
    .wr_addr    (host_addr),
    .wr_data    (host_wdata),
    .host_raddr (host_addr),
    .host_rdata (host_rdata),
    .rd_addr    (ptr_bus),
    .rd_data    (ent_bus)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic [ENTRY_W-1:0] ent;
    assign ent = ent_bus[s*ENTRY_W +: ENTRY_W];

    rt_sect_seq #(.IDX_W(SLOT_AW), .ADDR_W(ADDR_W), .SEC_ID(s)) u_seq (
      .clk      (clk),
      .rst_n    (srst_n),
      .chg_req  (chg_req[s]),
      .fsync    (frame_sync[s]),
      .tick     (slot_tick[s]),
      .ent_last (ent[F_LAST]),
      .ent_wrap (ent[F_WRAP]),
      .half_o   (live_half[s]),
      .pend_o   (chg_pend[s]),
      .ptr_o    (ptr_bus[s*ADDR_W +: ADDR_W])
    );

    assign slot_strobe[s] = ent[F_STB];

    // idle section keeps its state while others act
    assert_isolated_R11: assert property (@(posedge clk) disable iff (!srst_n)
      !(chg_req[s] || frame_sync[s] || slot_tick[s]) |=>
        ($stable(live_half[s]) && $stable(chg_pend[s]) &&
         $stable(exec_ptr[s*ADDR_W +: ADDR_W])));
  end

  assign exec_ptr   = ptr_bus;
  assign slot_entry = ent_bus;

  assert_reject_pulse_R10: assert property (@(posedge clk) disable iff (!srst_n)
    wr_reject |=> (!wr_reject || $past(host_we)));
endmodule

// File: tb/rt_route_table_tb.sv
module rt_route_table_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [8:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        wr_reject;
  logic [3:0]  chg_req, frame_sync, slot_tick;
  logic [3:0]  live_half, chg_pend, slot_strobe;
  logic [35:0] exec_ptr;
  logic [63:0] slot_entry;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_route_table dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .wr_reject(wr_reject),
    .chg_req(chg_req), .frame_sync(frame_sync), .slot_tick(slot_tick),
    .live_half(live_half), .chg_pend(chg_pend), .exec_ptr(exec_ptr),
    .slot_entry(slot_entry), .slot_strobe(slot_strobe)
  );

  function automatic int addr_of(int s, int h, int i);
    return s*128 + h*64 + i;
  endfunction

  function automatic int ptr_of(int s);
    return int'(exec_ptr[s*9 +: 9]);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    host_we = 1'b1; host_addr = 9'(a); host_wdata = 16'(d);
    step(1);
    host_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    host_addr = 9'(a);
    step(1);
    d = int'(host_rdata);
  endtask

  task automatic tick(logic [3:0] m, int n);
    repeat (n) begin slot_tick = m; step(1); slot_tick = 4'h0; end
  endtask

  task automatic sync(logic [3:0] m);
    frame_sync = m; step(1); frame_sync = 4'h0;
  endtask

  task automatic req(logic [3:0] m);
    chg_req = m; step(1); chg_req = 4'h0;
  endtask

  task automatic t_reset;
    chk("R1 half", live_half, 0);
    chk("R1 pend", chg_pend, 0);
    chk("R1 reject", wr_reject, 0);
    for (int s = 0; s < 4; s++) chk("R1 R2 ptr", ptr_of(s), addr_of(s, 0, 0));
  endtask

  task automatic fill_half(int h, string req);
    int rej = 0;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 64; i++) begin
        int v = 0;
        if (h == 1 && s == 0 && i == 5) v = 4;   // strobe entry
        if (h == 1 && s == 1 && i == 3) v = 3;   // last + wrap
        if (h == 1 && s == 2 && i == 2) v = 1;   // last, hold
        wr(addr_of(s, h, i), v);
        if (wr_reject) rej++;
      end
    chk(req, rej, 0);
  endtask

  task automatic t_fill_shadow;
    int d;
    fill_half(1, "R9 shadow writes accepted");
    rd(69, d);  chk("R9 readback 69", d, 4);
    rd(195, d); chk("R9 readback 195", d, 3);
    rd(322, d); chk("R9 readback 322", d, 1);
    rd(100, d); chk("R9 readback 100", d, 0);
  endtask

  task automatic t_request_waits;
    req(4'hF);
    chk("R4 pend set", chg_pend, 15);
    chk("R4 half kept", live_half, 0);
    step(3);
    chk("R4 still kept", live_half, 0);
  endtask

  task automatic t_swap_all;
    sync(4'hF);
    chk("R3 swapped", live_half, 15);
    chk("R3 cleared", chg_pend, 0);
    for (int s = 0; s < 4; s++) chk("R5 R2 ptr new base", ptr_of(s), addr_of(s, 1, 0));
  endtask

  task automatic t_reject;
    int d;
    fill_half(0, "R9 old half writable");
    wr(69, 16'hFFFF);
    chk("R10 flag", wr_reject, 1);
    step(1);
    chk("R10 one cycle", wr_reject, 0);
    rd(69, d);
    chk("R10 kept word", d, 4);
  endtask

  task automatic t_step_strobe;
    tick(4'h1, 5);
    chk("R6 advance", ptr_of(0), 69);
    chk("R8 strobe on", slot_strobe, 1);
    chk("R8 entry", int'(slot_entry[15:0]), 4);
    chk("R11 sec1", ptr_of(1), 192);
    chk("R11 sec2", ptr_of(2), 320);
    chk("R11 sec3", ptr_of(3), 448);
    tick(4'h1, 1);
    chk("R6 next", ptr_of(0), 70);
    chk("R8 strobe off", slot_strobe, 0);
    tick(4'h1, 57);
    chk("R6 slot 63", ptr_of(0), 127);
    tick(4'h1, 1);
    chk("R6 rollover", ptr_of(0), 64);
  endtask

  task automatic t_last;
    tick(4'h2, 3);
    chk("R7 at wrap entry", ptr_of(1), 195);
    tick(4'h2, 1);
    chk("R7 wrap to base", ptr_of(1), 192);
    tick(4'h4, 2);
    chk("R7 at hold entry", ptr_of(2), 322);
    tick(4'h4, 2);
    chk("R7 held", ptr_of(2), 322);
  endtask

  task automatic t_sync_nopend;
    sync(4'h4);
    chk("R5 restart", ptr_of(2), 320);
    chk("R3 no swap", live_half, 15);
  endtask

  task automatic t_independent;
    req(4'h1);
    sync(4'hF);
    chk("R11 only sec0 swapped", live_half, 14);
    chk("R11 pend clear", chg_pend, 0);
    chk("R11 sec0 ptr", ptr_of(0), 0);
    chk("R11 sec1 ptr", ptr_of(1), 192);
  endtask

  task automatic t_same_edge;
    chg_req = 4'h2; frame_sync = 4'h2;
    step(1);
    chg_req = 4'h0; frame_sync = 4'h0;
    chk("R12 no swap", live_half, 14);
    chk("R12 kept pending", chg_pend, 2);
    sync(4'h2);
    chk("R12 later swap", live_half, 12);
    chk("R12 ptr", ptr_of(1), 128);
  endtask

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    chg_req = '0; frame_sync = '0; slot_tick = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_fill_shadow();
    t_request_waits();
    t_swap_all();
    t_reject();
    t_step_strobe();
    t_last();
    t_sync_nopend();
    t_independent();
    t_same_edge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule